// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous NRZ frame on a single serial output. The line rests at mark (1). A frame is one start bit (0), a character field, and one stop bit (1). Four configuration inputs shape the character field: character length (8 or 9 bits), parity on or off, parity sense (even or odd), and bit order (least or most significant bit first). When parity is on, the parity bit takes the last slot of the character field. The field is therefore never longer, but it carries one data bit fewer. The parity bit always goes out last, whatever the bit order.

A character is handed over on a valid/ready handshake with a 9-bit data word. The configuration is sampled in the same cycle as the data, so it may change freely while a frame is in flight. Bit timing comes from an external baud tick: a one-cycle pulse per bit period. After acceptance the line stays at mark until the next tick. From that tick on, every tick moves the line to the next bit. The tick that ends the stop bit returns the block to idle and raises a one-cycle done pulse. With parity off, the highest data bit of the character is the address-mark flag.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever idle, `tx_line` is 1, `in_ready` is 1, `busy` is 0 and `frame_done` is 0. Baud ticks while idle leave the line at 1.
- R2: After a character is accepted, the first baud tick drives the start bit (0). The last bit of every frame is one stop bit (1), placed after the character field.
- R3: With `cfg_nine`=0 and `cfg_par_en`=0, the eight bits `in_data[7:0]` are sent between start and stop.
- R4: With `cfg_par_en`=1, the character field keeps its length (8 bits, or 9 when `cfg_nine`=1). It holds the low 7 (or 8) data bits followed by one parity bit, and parity is the last bit before stop in both bit orders.
- R5: With `cfg_nine`=1 and `cfg_par_en`=0, the nine bits `in_data[8:0]` are sent. In LSB-first order, bit 8 (the address-mark flag) is the last bit before stop.
- R6: `cfg_msb_first`=0 sends data bit 0 first. `cfg_msb_first`=1 sends the highest sent data bit first, down to bit 0.
- R7: The parity bit makes the number of ones among the sent data bits plus parity even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R8: `tx_line` changes only in the cycle after a baud tick, so each bit is held for exactly one tick interval.
- R9: `in_ready` is 1 only while idle. While a frame is in flight, `in_valid`, `in_data` and all `cfg_*` inputs have no effect on the frame being sent.
- R10: `frame_done` is a single-cycle pulse. It is raised in the same cycle the line leaves the stop bit and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_nine | input | 1 | 1: 9-bit character field, 0: 8-bit |
| cfg_par_en | input | 1 | 1: parity replaces the last field slot |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_data | input | 9 | Character; unused high bits ignored |
| tx_line | output | 1 | Serial output, idles at 1 |
| busy | output | 1 | Frame pending or in progress |
| frame_done | output | 1 | Pulse at end of stop bit |

## Verification
The corner cases are the parity modes, where a design that appends parity sends one slot too many. A design that leaves parity out of its place in MSB-first order puts parity first, or sends bit 7 instead of bit 6. Odd parity on an all-zero character must give a 1, which shows whether the sense is inverted. A design that counts the unsent top bit in the parity gets it wrong for characters with bit 7 or 8 set. The bench also changes the data and configuration in the middle of a frame, which shows any design that reads them after acceptance. It inserts idle cycles between ticks, which shows any design that advances without a tick or stretches the stop bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SEND  = 2'd2
  } tx_state_t;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic msb_first;
  } tx_cfg_t;

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 2,
  parameter int IDX_W   = $clog2(FRAME_W)
) (
  input  tx_cfg_t              cfg,
  input  logic [DATA_W-1:0]    data,
  output logic [FRAME_W-1:0]   frame,
  output logic [IDX_W-1:0]     last_idx
);

  localparam int BIT_IW = $clog2(DATA_W);

  // width of the character field between start and stop
  function automatic int field_width(input tx_cfg_t c);
    return c.nine ? DATA_W : DATA_W - 1;
  endfunction

  // number of real data bits inside the field
  function automatic int data_count(input tx_cfg_t c);
    return field_width(c) - (c.par_en ? 1 : 0);
  endfunction

  function automatic logic parity_of(input tx_cfg_t c, input logic [DATA_W-1:0] d);
    logic p;
    p = c.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < data_count(c)) p = p ^ d[BIT_IW'(i)];
    end
    return p;
  endfunction

  // frame is sent starting at bit 0: start, field, stop, then mark fill
  function automatic logic [FRAME_W-1:0] build_frame(input tx_cfg_t c,
                                                     input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    int n;
    n = data_count(c);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        if (c.msb_first) f[IDX_W'(i + 1)] = d[BIT_IW'(n - 1 - i)];
        else             f[IDX_W'(i + 1)] = d[BIT_IW'(i)];
      end
    end
    if (c.par_en) f[IDX_W'(n + 1)] = parity_of(c, d);
    return f;
  endfunction

  always_comb begin
    frame    = build_frame(cfg, data);
    last_idx = IDX_W'(field_width(cfg) + 1);
  end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int IDX_W   = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [IDX_W-1:0]   last_idx,
  output logic               tx_line,
  output logic               busy,
  output logic               done
);

  tx_state_t          state;
  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   last_q;

  // named events for the assertions
  logic start_evt;
  logic stop_evt;
  logic shift_evt;

  assign start_evt = (state == TX_ARMED) && baud_tick;
  assign stop_evt  = (state == TX_SEND) && baud_tick && (idx == last_q);
  assign shift_evt = (state == TX_SEND) && baud_tick && !stop_evt;
  assign busy      = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '1;
      idx     <= '0;
      last_q  <= '0;
      tx_line <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= stop_evt;
      unique case (state)
        TX_IDLE: begin
          if (load) begin
            shreg  <= frame_in;
            last_q <= last_idx;
            state  <= TX_ARMED;
          end
        end
        TX_ARMED: begin
          if (start_evt) begin
            tx_line <= shreg[0];
            shreg   <= {1'b1, shreg[FRAME_W-1:1]};
            idx     <= '0;
            state   <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (stop_evt) begin
            tx_line <= 1'b1;
            state   <= TX_IDLE;
          end else if (shift_evt) begin
            tx_line <= shreg[0];
            shreg   <= {1'b1, shreg[FRAME_W-1:1]};
            idx     <= idx + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !tx_line);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tx_line));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_msb_first,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              tx_line,
  output logic              busy,
  output logic              frame_done
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  tx_cfg_t            cfg;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   last_idx;
  logic               accept;

  assign cfg      = '{nine: cfg_nine, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, msb_first: cfg_msb_first};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_framer (
    .cfg      (cfg),
    .data     (in_data),
    .frame    (frame),
    .last_idx (last_idx)
  );

  uart_tx_seq #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .load      (accept),
    .frame_in  (frame),
    .last_idx  (last_idx),
    .tx_line   (tx_line),
    .busy      (busy),
    .done      (frame_done)
  );

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && tx_line));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> busy);

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  localparam int CLK_P = 10;
  localparam int GAP   = 2;
  localparam int WDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_msb_first = 1'b0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready, tx_line, busy, frame_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_msb_first(cfg_msb_first), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_line(tx_line), .busy(busy), .frame_done(frame_done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected line value in slot k (0 = start) from the requirements
  function automatic logic exp_slot(input logic [8:0] d, input logic nine, input logic pen,
                                    input logic odd, input logic msb, input int k);
    int field = nine ? 9 : 8;
    int ndat  = pen ? field - 1 : field;
    int ones  = 0;
    if (k == 0) return 1'b0;
    if (k > field) return 1'b1;
    if (pen && k == field) begin
      for (int b = 0; b < ndat; b++) ones += d[b];
      return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    end
    return msb ? d[ndat - k] : d[k - 1];
  endfunction

  function automatic string slot_tag(input logic nine, input logic pen, input logic msb,
                                     input int k);
    int field = nine ? 9 : 8;
    if (k == 0 || k > field) return "R2";
    if (pen && k == field) return "R7";
    if (msb) return "R6";
    if (pen) return "R4";
    if (nine) return "R5";
    return "R3";
  endfunction

  // tick for one cycle; on return the line already reflects that tick
  task automatic tick_once();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input logic nine, input logic pen,
                      input logic odd, input logic msb, input logic disturb);
    int field = nine ? 9 : 8;
    logic held;
    @(negedge clk);
    cfg_nine = nine; cfg_par_en = pen; cfg_par_odd = odd; cfg_msb_first = msb;
    in_data = d; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R9 ready when idle", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy == 1'b1 && in_ready == 1'b0, "R9 busy after accept", int'(busy), 1);
    chk(tx_line == 1'b1, "R2 mark until first tick", int'(tx_line), 1);
    if (disturb) begin
      in_valid = 1'b1; in_data = ~d;
      cfg_nine = ~nine; cfg_par_en = ~pen; cfg_par_odd = ~odd; cfg_msb_first = ~msb;
    end
    for (int k = 0; k <= field + 1; k++) begin
      tick_once();
      chk(tx_line == exp_slot(d, nine, pen, odd, msb, k), slot_tag(nine, pen, msb, k),
          int'(tx_line), int'(exp_slot(d, nine, pen, odd, msb, k)));
      chk(frame_done == 1'b0 && busy == 1'b1, "R10 no early done", int'(frame_done), 0);
      held = tx_line;
      for (int g = 0; g < GAP; g++) begin
        @(negedge clk);
        chk(tx_line == held, "R8 line held between ticks", int'(tx_line), int'(held));
      end
    end
    tick_once();
    in_valid = 1'b0;
    chk(frame_done == 1'b1, "R10 done pulse", int'(frame_done), 1);
    chk(busy == 1'b0 && tx_line == 1'b1, "R10 idle with done", int'(busy), 0);
    @(negedge clk);
    chk(frame_done == 1'b0, "R10 done single cycle", int'(frame_done), 0);
    chk(tx_line == 1'b1 && in_ready == 1'b1, "R1 idle after frame", int'(tx_line), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1 && in_ready == 1'b1, "R1 reset line/ready", int'(tx_line), 1);
    chk(busy == 1'b0 && frame_done == 1'b0, "R1 reset busy/done", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1 && busy == 1'b0, "R1 out of reset", int'(tx_line), 1);
    tick_once();
    tick_once();
    chk(tx_line == 1'b1 && busy == 1'b0, "R1 idle ticks keep mark", int'(tx_line), 1);

    // directed: every mode combination on a mixed pattern
    for (int m = 0; m < 16; m++)
      send(9'h1A5, m[3], m[2], m[1], m[0], 1'b0);
    // parity sense on all-zero and all-one characters (R7)
    send(9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send(9'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    send(9'h1FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // unsent top bits must not enter parity (R4, R7)
    send(9'h180, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(9'h100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    // address mark: bit 8 alone, LSB first, 9-bit, no parity (R5)
    send(9'h100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // inputs disturbed mid-frame (R9)
    send(9'h0C3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    send(9'h13C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // random frames
    for (int r = 0; r < 30; r++) begin
      logic [31:0] rv;
      rv = $urandom;
      send(rv[8:0], rv[9], rv[10], rv[11], rv[12], rv[13]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule